// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This unit turns an engine clock into CAN time quanta and lays out each bit as four segments: a one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. Two engine clocks arrive as clock-enable pulses in the system clock domain. A latched select picks one of them, and a programmable prescaler divides its pulses down to the quantum tick. At the end of phase segment 1 the unit raises a sample strobe and captures the received line. On the tick that closes phase segment 2 it raises a bit-start strobe, which also serves as the transmit point for the next bit.

The unit watches the received line for recessive-to-dominant transitions. An edge seen after the sync segment and before phase segment 2 means the sender runs late, so phase segment 1 is stretched. An edge seen inside phase segment 2 means the sender runs early, so phase segment 2 is cut short. Each correction is capped by the programmed jump width. Only one correction is allowed per bit. All length fields are programmed as the desired length minus one.

Top module: `can_bit_timer`

## Requirements
- R1: With the quantum divider field `presc` = P, `tq_tick` pulses once every P+1 pulses of the selected engine enable. P = 0 gives a tick on every pulse, and P = 255 gives one tick per 256 pulses.
- R2: `clk_sel` = 0 selects `osc_ce` and `clk_sel` = 1 selects `bus_ce`. The selection is captured only while `en` is low, and a change of `clk_sel` while `en` is high has no effect.
- R3: While `en` is low, `tq_tick`, `sample_stb` and `bit_start` stay low and the bit timing returns to its start. After reset `rx_bit` is 1 and all strobes are 0.
- R4: With no falling edges on `rx`, each bit lasts N = 1 + (`prop_len`+1) + (`ph1_len`+1) + (`ph2_len`+1) quanta. `bit_start` is raised on the tick that ends each bit. `sample_stb` and `bit_start` never coincide.
- R5: `sample_stb` is raised on the tick that ends phase segment 1. With no correction this is the (`prop_len`+`ph1_len`+3)-th tick after `bit_start`. `rx_bit` takes the value of `rx` from that cycle one cycle later, and it holds at all other times.
- R6: A `ph2_len` code of 0 is treated as 1, so phase segment 2 is never shorter than 2 quanta.
- R7: Number the quanta of a bit from 0, starting at its sync segment. A falling edge of `rx` in quantum k, with 1 ≤ k ≤ `prop_len`+`ph1_len`+2, lengthens phase segment 1 and the bit by min(k, `sjw`+1) quanta. The sample strobe moves later by the same amount.
- R8: A falling edge of `rx` in quantum k inside phase segment 2 shortens the bit by min(N−1−k, `sjw`+1) quanta. The sample point of that bit does not change.
- R9: A falling edge in quantum 0 (the sync segment) changes nothing, and rising edges of `rx` change nothing.
- R10: At most one correction happens per bit. After a correction, further falling edges in the same bit are ignored.
- R11: `sample_stb` and `bit_start` are only raised in a cycle where `tq_tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_ce | input | 1 | Engine pulse from the oscillator source |
| bus_ce | input | 1 | Engine pulse from the bus clock source |
| en | input | 1 | Unit enable; low holds timing at rest and allows the source select to load |
| clk_sel | input | 1 | Engine source select (0 oscillator, 1 bus) |
| presc | input | 8 | Quantum divider, ratio minus one |
| sjw | input | 2 | Jump width minus one |
| prop_len | input | 3 | Propagation segment length minus one |
| ph1_len | input | 3 | Phase segment 1 length minus one |
| ph2_len | input | 3 | Phase segment 2 length minus one (0 treated as 1) |
| rx | input | 1 | Received bus line (1 recessive) |
| tq_tick | output | 1 | Quantum tick, one cycle wide |
| sample_stb | output | 1 | Sample point strobe |
| rx_bit | output | 1 | Last sampled bus value |
| bit_start | output | 1 | Strobe on the tick that starts a new bit |

## Verification
`tq_tick`, `sample_stb` and `bit_start` are decoded from registered state in the same cycle as the engine pulse that completes a quantum. `rx_bit` changes one cycle after `sample_stb`. The bench samples every output on the falling clock edge. It measures bit length and sample position by counting ticks from one `bit_start` to the next, and it checks `rx_bit` on the falling edge that follows a sample strobe. Resync edges are driven on a falling edge inside a chosen quantum, so the quantum index each edge lands in is known exactly, and the expected stretch or cut follows from that index.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PRESC_W = 8,
  parameter int SEG_W   = 3,
  parameter int SJW_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_ce,
  input  logic               bus_ce,
  input  logic               en,
  input  logic               clk_sel,
  input  logic [PRESC_W-1:0] presc,
  input  logic [SJW_W-1:0]   sjw,
  input  logic [SEG_W-1:0]   prop_len,
  input  logic [SEG_W-1:0]   ph1_len,
  input  logic [SEG_W-1:0]   ph2_len,
  input  logic               rx,
  output logic               tq_tick,
  output logic               sample_stb,
  output logic               rx_bit,
  output logic               bit_start
);

  localparam int W = $clog2(2 * (1 << SEG_W) + (1 << SJW_W) + 2) + 1;

  typedef enum logic [1:0] {SYNC, PROP, PH1, PH2} seg_t;

  logic               sel_q;
  logic [PRESC_W-1:0] pcnt;
  seg_t               seg;
  logic [W-1:0]       cnt, ext, shr, ext_n, shr_n;
  logic               rx_q, done, last_q;

  function automatic logic [W-1:0] lesser(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  wire          eng    = sel_q ? bus_ce : osc_ce;
  wire [W-1:0]  prop_w = W'(prop_len);
  wire [W-1:0]  ph1_w  = W'(ph1_len);
  wire [W-1:0]  ph2_w  = (ph2_len == '0) ? W'(1) : W'(ph2_len);
  wire [W-1:0]  jump   = W'(sjw) + W'(1);

  assign tq_tick = en & eng & (pcnt >= presc);

  wire fall   = en & rx_q & ~rx;
  wire accept = fall & ~done & (seg != SYNC);

  wire [W-1:0] err_late  = (seg == PROP) ? cnt + W'(1) : prop_w + cnt + W'(2);
  wire [W-1:0] err_early = ph2_w - cnt;

  assign ext_n = (accept && (seg == PROP || seg == PH1)) ? lesser(err_late, jump) : ext;
  assign shr_n = (accept && seg == PH2) ? lesser(err_early, jump) : shr;

  wire ph1_end = (seg == PH1) && (cnt == ph1_w + ext_n);
  wire ph2_end = (seg == PH2) && (cnt == ph2_w - shr_n);

  always_comb begin
    case (seg)
      SYNC:    last_q = 1'b1;
      PROP:    last_q = (cnt == prop_w);
      PH1:     last_q = ph1_end;
      default: last_q = ph2_end;
    endcase
  end

  assign sample_stb = tq_tick & ph1_end;
  assign bit_start  = tq_tick & ph2_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      pcnt   <= '0;
      seg    <= SYNC;
      cnt    <= '0;
      ext    <= '0;
      shr    <= '0;
      done   <= 1'b0;
      rx_q   <= 1'b1;
      rx_bit <= 1'b1;
    end else if (!en) begin
      sel_q <= clk_sel;
      pcnt  <= '0;
      seg   <= SYNC;
      cnt   <= '0;
      ext   <= '0;
      shr   <= '0;
      done  <= 1'b0;
      rx_q  <= 1'b1;
    end else begin
      rx_q <= rx;
      if (eng)
        pcnt <= (pcnt >= presc) ? '0 : pcnt + PRESC_W'(1);
      if (bit_start) begin
        done <= 1'b0;
        ext  <= '0;
        shr  <= '0;
      end else begin
        done <= done | accept;
        ext  <= ext_n;
        shr  <= shr_n;
      end
      if (tq_tick) begin
        if (last_q) begin
          cnt <= '0;
          case (seg)
            SYNC:    seg <= PROP;
            PROP:    seg <= PH1;
            PH1:     seg <= PH2;
            default: seg <= SYNC;
          endcase
        end else begin
          cnt <= cnt + W'(1);
        end
      end
      if (sample_stb)
        rx_bit <= rx;
    end
  end

endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic tq_tick,
  input logic sample_stb,
  input logic bit_start,
  input logic rx_bit,
  input logic sel_q
);

  assert_sample_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> tq_tick);

  assert_start_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |-> tq_tick);

  assert_quiet_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!tq_tick && !sample_stb && !bit_start));

  assert_select_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(sel_q));

  assert_rxbit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_stb) |-> $stable(rx_bit));

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_start));

endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tq_tick(tq_tick),
  .sample_stb(sample_stb), .bit_start(bit_start), .rx_bit(rx_bit), .sel_q(sel_q)
);

// File: tb/can_bit_timer_test.sv
`timescale 1ns/1ps
module can_bit_timer_test;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       osc_ce = 1'b1, bus_ce = 1'b0, en = 1'b0, clk_sel = 1'b0;
  logic [7:0] presc = 8'd3;
  logic [1:0] sjw = 2'd0;
  logic [2:0] prop_len = 3'd1, ph1_len = 3'd1, ph2_len = 3'd1;
  logic       rx = 1'b1;
  logic       tq_tick, sample_stb, rx_bit, bit_start;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  always @(negedge clk) bus_ce <= ~bus_ce;

  can_bit_timer uut (
    .clk(clk), .rst_n(rst_n), .osc_ce(osc_ce), .bus_ce(bus_ce), .en(en),
    .clk_sel(clk_sel), .presc(presc), .sjw(sjw), .prop_len(prop_len),
    .ph1_len(ph1_len), .ph2_len(ph2_len), .rx(rx), .tq_tick(tq_tick),
    .sample_stb(sample_stb), .rx_bit(rx_bit), .bit_start(bit_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nom_len(int p, int a, int b);
    return 4 + p + a + ((b == 0) ? 1 : b);
  endfunction

  function automatic int first_k(int k1, int k2);
    if (k1 >= 1) return k1;
    if (k2 >= 1) return k2;
    return -1;
  endfunction

  function automatic int exp_len(int p, int a, int b, int s, int k1, int k2);
    int n = nom_len(p, a, b);
    int k = first_k(k1, k2);
    int j = s + 1;
    if (k < 1) return n;
    if (k <= p + a + 2) return n + ((k < j) ? k : j);
    return n - (((n - 1 - k) < j) ? (n - 1 - k) : j);
  endfunction

  function automatic int exp_sp(int p, int a, int s, int k1, int k2);
    int k = first_k(k1, k2);
    int j = s + 1;
    if (k >= 1 && k <= p + a + 2) return p + a + 3 + ((k < j) ? k : j);
    return p + a + 3;
  endfunction

  task automatic setup(input int p, input int a, input int b, input int s);
    @(negedge clk);
    en = 1'b0; rx = 1'b1;
    presc = 8'd3; prop_len = 3'(p); ph1_len = 3'(a); ph2_len = 3'(b); sjw = 2'(s);
    repeat (2) @(negedge clk);
    en = 1'b1;
  endtask

  task automatic run_bit(input int k1, input int k2, input bit hold, output int len, output int sp);
    int t = 0, rt = -1, cyc = 0;
    bit d1 = 0, d2 = 0, pend = 0, rx_at = 1;
    sp = -1;
    do @(negedge clk); while (!bit_start);
    forever begin
      @(negedge clk);
      cyc++;
      if (pend) begin
        check(rx_bit == rx_at, "R5 rx_bit after sample", int'(rx_bit), int'(rx_at));
        pend = 0;
      end
      if (rt == cyc && !hold) rx = 1'b1;
      if (!d1 && k1 >= 0 && t == k1) begin rx = 1'b0; d1 = 1; rt = cyc + 2; end
      else if (!d2 && k2 >= 0 && t == k2) begin rx = 1'b0; d2 = 1; rt = cyc + 2; end
      if (sample_stb) begin sp = t + 1; pend = 1; rx_at = rx; end
      if (tq_tick) t++;
      if (bit_start) break;
    end
    len = t;
    if (pend) begin
      @(negedge clk);
      check(rx_bit == rx_at, "R5 rx_bit after sample", int'(rx_bit), int'(rx_at));
    end
  endtask

  task automatic tick_gap(output int g);
    g = 0;
    do @(negedge clk); while (!tq_tick);
    do begin @(negedge clk); g++; end while (!tq_tick);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int g, len, sp, bad;
    int p, a, b, s, n, k1, k2;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    check(!tq_tick && !sample_stb && !bit_start, "R3 strobes in reset", int'(tq_tick), 0);
    check(rx_bit == 1'b1, "R3 rx_bit reset value", int'(rx_bit), 1);
    rst_n = 1'b1;

    bad = 0;
    repeat (20) begin @(negedge clk); if (tq_tick || sample_stb || bit_start) bad++; end
    check(bad == 0, "R3 quiet while disabled", bad, 0);

    // R1: divider on oscillator pulses
    foreach (g_list[i]) ;
    presc = 8'd0; en = 1'b1;
    tick_gap(g); check(g == 1, "R1 presc 0 gap", g, 1);
    @(negedge clk); en = 1'b0; presc = 8'd255; @(negedge clk); en = 1'b1;
    tick_gap(g); check(g == 256, "R1 presc 255 gap", g, 256);
    for (int i = 0; i < 6; i++) begin
      int pv = $urandom_range(40, 1);
      @(negedge clk); en = 1'b0; presc = 8'(pv); @(negedge clk); en = 1'b1;
      tick_gap(g); check(g == pv + 1, "R1 random presc gap", g, pv + 1);
    end

    // R2: selection held while enabled, loaded while disabled
    @(negedge clk); en = 1'b0; presc = 8'd4; clk_sel = 1'b0; @(negedge clk); en = 1'b1;
    clk_sel = 1'b1;
    tick_gap(g); check(g == 5, "R2 select ignored while enabled", g, 5);
    @(negedge clk); en = 1'b0; @(negedge clk); en = 1'b1;
    tick_gap(g); check(g == 10, "R2 bus source gap", g, 10);
    @(negedge clk); en = 1'b0; presc = 8'd0; @(negedge clk); en = 1'b1;
    tick_gap(g); check(g == 2, "R2 bus source presc 0", g, 2);
    @(negedge clk); en = 1'b0; clk_sel = 1'b0; @(negedge clk);

    // R4/R5: nominal bits, extreme fields
    setup(0, 0, 1, 0);
    run_bit(-1, -1, 0, len, sp);
    run_bit(-1, -1, 0, len, sp);
    check(len == 5, "R4 shortest bit", len, 5);
    check(sp == 3, "R5 sample point shortest", sp, 3);
    setup(7, 7, 7, 3);
    run_bit(-1, -1, 0, len, sp);
    run_bit(-1, -1, 0, len, sp);
    check(len == 25, "R4 longest bit", len, 25);
    check(sp == 17, "R5 sample point longest", sp, 17);

    // R6: phase 2 code 0 behaves as 1
    setup(2, 3, 0, 1);
    run_bit(-1, -1, 0, len, sp);
    run_bit(-1, -1, 0, len, sp);
    check(len == nom_len(2, 3, 1), "R6 ph2 code 0 length", len, nom_len(2, 3, 1));

    // R9: edge in sync segment ignored
    setup(2, 2, 3, 3);
    run_bit(-1, -1, 0, len, sp);
    run_bit(0, -1, 0, len, sp);
    check(len == nom_len(2, 2, 3), "R9 sync edge no change", len, nom_len(2, 2, 3));
    check(sp == 7, "R9 sync edge sample unchanged", sp, 7);

    // R7: lengthening capped by jump width
    setup(3, 4, 3, 0);
    run_bit(-1, -1, 0, len, sp);
    run_bit(6, -1, 0, len, sp);
    check(len == nom_len(3, 4, 3) + 1, "R7 stretch capped at sjw", len, nom_len(3, 4, 3) + 1);
    check(sp == 11, "R7 sample moved", sp, 11);

    // R8: shortening in phase 2
    setup(1, 1, 6, 3);
    run_bit(-1, -1, 0, len, sp);
    run_bit(7, -1, 0, len, sp);
    check(len == exp_len(1, 1, 6, 3, 7, -1), "R8 phase 2 cut", len, exp_len(1, 1, 6, 3, 7, -1));
    check(sp == 5, "R8 sample unchanged", sp, 5);

    // R10: second edge in same bit ignored
    setup(2, 5, 4, 3);
    run_bit(-1, -1, 0, len, sp);
    run_bit(1, 5, 0, len, sp);
    check(len == nom_len(2, 5, 4) + 1, "R10 one correction per bit", len, nom_len(2, 5, 4) + 1);

    // R5: dominant value captured
    setup(2, 2, 2, 0);
    run_bit(-1, -1, 0, len, sp);
    run_bit(2, -1, 1, len, sp);
    check(rx_bit == 1'b0, "R5 dominant sampled", int'(rx_bit), 0);
    @(negedge clk); rx = 1'b1;

    // Random mix over R4, R5, R7, R8, R9, R10
    for (int it = 0; it < 40; it++) begin
      p = $urandom_range(7, 0); a = $urandom_range(7, 0);
      b = $urandom_range(7, 0); s = $urandom_range(3, 0);
      n = nom_len(p, a, b);
      k1 = int'($urandom_range(n, 0)) - 1;
      k2 = (k1 >= 0 && k1 < n - 2 && $urandom_range(1, 0) == 1) ? k1 + 1 + int'($urandom_range(n - 2 - k1, 0)) : -1;
      setup(p, a, b, s);
      run_bit(-1, -1, 0, len, sp);
      run_bit(k1, k2, 0, len, sp);
      check(len == exp_len(p, a, b, s, k1, k2), "R7 R8 R10 random bit length", len, exp_len(p, a, b, s, k1, k2));
      check(sp == exp_sp(p, a, s, k1, k2), "R5 R7 random sample point", sp, exp_sp(p, a, s, k1, k2));
    end

    finish_run();
  end

  int g_list[1];

endmodule